// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines from peripheral cores inside a chip and condenses them into a single interrupt line toward a host processor. Each line is recorded as pending when it fires. Software chooses which lines may interrupt through a mask that is changed with separate set and clear writes, so no read-modify-write is needed. Lines are edge sensitive (rising or falling) or level sensitive, chosen per line by parameters.

When the controller is idle and globally enabled, it picks the lowest-numbered line that is both pending and unmasked. It latches that line's handler word from a 32-entry vector table into a vector register and holds it there until software writes the end-of-interrupt register. Software may also raise any line by writing to a software request register. The host line is either a level that follows "some unmasked line is pending" or a pulse of a programmed number of cycles for each new interrupt taken. A polarity bit inverts the line in both modes.

All access goes through a simple 32-bit register bus: a write strobe with address and data, and read data that follows the address combinationally.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 (control, pending, mask, vector, table), nothing is in service and the host line is low.
- R2: An edge line (bit set in SRC_EDGE) becomes pending on its active transition only: rising when its SRC_RISE bit is 1, falling when 0. The opposite transition and a held level are ignored, and the detector starts from the idle level (0 for rising, 1 for falling).
- R3: A level line (bit clear in SRC_EDGE) is made pending on every cycle it sits at its active level (high when its SRC_RISE bit is 1). If it is still active when its end-of-interrupt arrives, it stays pending. The pending set reads at offset 0x04 (bit i = line i) and ignores writes.
- R4: Writing offset 0x08 sets every mask bit whose data bit is 1, and writing offset 0x0C clears every mask bit whose data bit is 1. Zero data bits change nothing, and the mask reads at offset 0x10. A pending line with a clear mask bit is never taken and does not drive the host line.
- R5: The vector table occupies offsets 0x80 + 4*i (entry i, one 32-bit word, read/write). When idle and enabled, the lowest-numbered line that is pending and unmasked is taken, and the vector register at 0x14 then returns table entry i.
- R6: While a line is in service the vector register does not change, even if a lower-numbered line becomes pending or the table is rewritten.
- R7: Any write to offset 0x1C while a line is in service clears that line's pending bit and ends service, and the vector register reads 0 until the next line is taken. Such a write with nothing in service changes nothing.
- R8: Writing offset 0x18 makes every line whose data bit is 1 pending, exactly as if its request had fired.
- R9: In level mode (control bit 2 = 0) the host line is active while some unmasked line is pending. In pulse mode (bit 2 = 1) each line taken gives one active pulse of exactly N cycles, where N is control bits 18:3 and 0 is treated as 1.
- R10: Control at 0x00: bit 0 global enable, bit 1 polarity (1 = active low), bit 2 pulse mode, bits 18:3 pulse length. With bit 0 clear no line is taken and the host line sits at its inactive level.
- R11: The write-only offsets 0x08, 0x0C, 0x18 and 0x1C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src_i | input | NUM_SRC | Request lines from peripheral cores, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt line toward the host |

## Verification
The bench drives level requests that are held across their own acknowledge, rising and falling edge requests with their opposite transitions, software requests, and requests whose mask bit is clear. Together these separate the pending-recording rules from arbitration and masking. It raises a lower-numbered line while another is in service, which tells a frozen vector register from one that re-arbitrates, and it acknowledges with nothing in service to show that such a write is harmless. The host line is tried in level mode at both polarities, and in pulse mode with a length of five and with a length of zero, which tells an exact pulse count from a stretched or missing one.

// File: rtl/vic_pkg.sv
// Package: shared constants and the control-register layout for the
// vectored interrupt controller. Assumes byte addressing of 32-bit words.
package vic_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_RAW  = 8'h04;
    localparam logic [7:0] OFS_SET  = 8'h08;
    localparam logic [7:0] OFS_CLR  = 8'h0C;
    localparam logic [7:0] OFS_MASK = 8'h10;
    localparam logic [7:0] OFS_VEC  = 8'h14;
    localparam logic [7:0] OFS_SOFT = 8'h18;
    localparam logic [7:0] OFS_EOI  = 8'h1C;

    // Width of the pulse-length field and of the whole control word
    localparam int LEN_W = 16;
    localparam int CTL_W = LEN_W + 3;

    // Control word: packed so that en is bit 0, pol bit 1, emu bit 2
    typedef struct packed {
        logic [LEN_W-1:0] plen;
        logic             emu;
        logic             pol;
        logic             en;
    } ctl_t;

endpackage

// File: rtl/vic_src_detect.sv
// Module: per-line request detection. Each line is either edge sensitive
// (rising or falling) or level sensitive, chosen by parameter bits.
// Assumes request lines are already synchronous to clk.
module vic_src_detect #(
    parameter int                   NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0]   EDGE_SEL = '0,
    parameter logic [NUM_SRC-1:0]   RISE_SEL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] hit_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        if (EDGE_SEL[g]) begin : g_edge
            logic prev_q;

            // Remember last cycle's level; start from the idle level
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= ~RISE_SEL[g];
                else        prev_q <= src_i[g];
            end

            if (RISE_SEL[g]) begin : g_rise
                assign hit_o[g] = src_i[g] & ~prev_q;
            end else begin : g_fall
                assign hit_o[g] = ~src_i[g] & prev_q;
            end
        end else begin : g_level
            assign hit_o[g] = (src_i[g] == RISE_SEL[g]);
        end
    end

endmodule

// File: rtl/vic_regs.sv
// Module: register file, vector table, pending and mask state.
// Decodes the bus, keeps the pending set (hardware and software set,
// end-of-interrupt clear, set wins), the mask (write-one set/clear) and
// the frozen vector register. Assumes one bus write per cycle at most.
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [NUM_SRC-1:0] hw_hit_i,
    input  logic               serving_i,
    input  logic [IDX_W-1:0]   cur_id_i,
    input  logic               capture_i,
    input  logic [IDX_W-1:0]   win_id_i,
    output ctl_t               ctl_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [DATA_W-1:0]  vec_o,
    output logic               eoi_wr_o
);

    logic [DATA_W-1:0]  table_q [NUM_SRC];
    ctl_t               ctl_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  vec_q;

    logic               wr_ctl, wr_set, wr_clr, wr_soft, tbl_sel;
    logic [IDX_W-1:0]   tbl_idx;
    logic [NUM_SRC-1:0] wbits, soft_hit, eoi_clr;

    // Address decode for each writable location
    assign wr_ctl   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CTL));
    assign wr_set   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_SET));
    assign wr_clr   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CLR));
    assign wr_soft  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_SOFT));
    assign eoi_wr_o = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_EOI));
    assign tbl_sel  = bus_addr_i[ADDR_W-1];
    assign tbl_idx  = bus_addr_i[IDX_W+1:2];
    assign wbits    = bus_wdata_i[NUM_SRC-1:0];

    // Software requests and the acknowledge of the line in service
    assign soft_hit = wr_soft ? wbits : '0;
    assign eoi_clr  = (eoi_wr_o && serving_i) ? (NUM_SRC'(1) << cur_id_i) : '0;

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= ctl_t'(bus_wdata_i[CTL_W-1:0]);
    end

    // Mask: write-one-to-set at one offset, write-one-to-clear at another
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (wr_set) mask_q <= mask_q | wbits;
        else if (wr_clr) mask_q <= mask_q & ~wbits;
    end

    // Pending set: acknowledge clears, any new request sets (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~eoi_clr) | hw_hit_i | soft_hit;
    end

    // Vector table, one word per line
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_tbl
        // Store a table word when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                table_q[i] <= '0;
            else if (bus_wr_i && tbl_sel && (tbl_idx == IDX_W'(i)))
                table_q[i] <= bus_wdata_i;
        end
    end

    // Vector register: loaded on capture, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                     vec_q <= '0;
        else if (capture_i)             vec_q <= table_q[win_id_i];
        else if (eoi_wr_o && serving_i) vec_q <= '0;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        if (tbl_sel) begin
            bus_rdata_o = table_q[tbl_idx];
        end else begin
            case (bus_addr_i)
                ADDR_W'(OFS_CTL):  bus_rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
                ADDR_W'(OFS_RAW):  bus_rdata_o = DATA_W'(pend_q);
                ADDR_W'(OFS_MASK): bus_rdata_o = DATA_W'(mask_q);
                ADDR_W'(OFS_VEC):  bus_rdata_o = vec_q;
                default:           bus_rdata_o = '0;
            endcase
        end
    end

    assign ctl_o     = ctl_q;
    assign pending_o = pend_q;
    assign mask_o    = mask_q;
    assign vec_o     = vec_q;

endmodule

// File: rtl/vic_arbiter.sv
// Module: fixed-priority arbiter with a single service slot. When idle
// and enabled it takes the lowest-numbered requesting line and holds it
// until an end-of-interrupt write. Assumes req_i is pending AND mask.
module vic_arbiter #(
    parameter int  NUM_SRC = 32,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               eoi_wr_i,
    output logic               serving_o,
    output logic [IDX_W-1:0]   cur_id_o,
    output logic               capture_o,
    output logic [IDX_W-1:0]   win_id_o
);

    logic             serving_q;
    logic [IDX_W-1:0] cur_q;
    logic             found;

    // Lowest-numbered requesting line wins
    always_comb begin
        found    = 1'b0;
        win_id_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && req_i[i]) begin
                found    = 1'b1;
                win_id_o = IDX_W'(i);
            end
        end
    end

    assign capture_o = !serving_q && glob_en_i && found;

    // Service slot: fill on capture, empty on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serving_q <= 1'b0;
            cur_q     <= '0;
        end else if (capture_o) begin
            serving_q <= 1'b1;
            cur_q     <= win_id_o;
        end else if (eoi_wr_i && serving_q) begin
            serving_q <= 1'b0;
        end
    end

    assign serving_o = serving_q;
    assign cur_id_o  = cur_q;

endmodule

// File: rtl/vic_out_shaper.sv
// Module: host line shaping. Level mode follows any unmasked pending
// line; pulse mode emits one pulse of plen cycles (0 counts as 1) per
// capture. Polarity inverts the result; disabled means inactive.
module vic_out_shaper #(
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               pol_i,
    input  logic               emu_i,
    input  logic [PULSE_W-1:0] plen_i,
    input  logic               any_req_i,
    input  logic               capture_i,
    output logic               irq_o
);

    logic [PULSE_W-1:0] cnt_q;
    logic               active;

    // Pulse timer: load on capture in pulse mode, then count down
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (capture_i && emu_i)
            cnt_q <= (plen_i == '0) ? PULSE_W'(1) : plen_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - PULSE_W'(1);
    end

    // Active condition for the selected mode, then polarity
    always_comb begin
        active = en_i && (emu_i ? (cnt_q != '0) : any_req_i);
        irq_o  = active ^ pol_i;
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: top of the vectored interrupt controller. Ties together the
// request detectors, the register file, the arbiter and the output
// shaper. Assumes a synchronous single-clock register bus.
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int                 NUM_SRC  = 32,
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 32,
    parameter logic [NUM_SRC-1:0] SRC_EDGE = '0,
    parameter logic [NUM_SRC-1:0] SRC_RISE = '1,
    localparam int                IDX_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] hw_hit, pending, mask;
    ctl_t               ctl_q;
    logic [DATA_W-1:0]  vec_q;
    logic               eoi_wr, serving, capture;
    logic [IDX_W-1:0]   cur_id, win_id;

    vic_src_detect #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_SEL (SRC_EDGE),
        .RISE_SEL (SRC_RISE)
    ) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (irq_src_i),
        .hit_o (hw_hit)
    );

    vic_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .hw_hit_i    (hw_hit),
        .serving_i   (serving),
        .cur_id_i    (cur_id),
        .capture_i   (capture),
        .win_id_i    (win_id),
        .ctl_o       (ctl_q),
        .pending_o   (pending),
        .mask_o      (mask),
        .vec_o       (vec_q),
        .eoi_wr_o    (eoi_wr)
    );

    vic_arbiter #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .glob_en_i (ctl_q.en),
        .req_i     (pending & mask),
        .eoi_wr_i  (eoi_wr),
        .serving_o (serving),
        .cur_id_o  (cur_id),
        .capture_o (capture),
        .win_id_o  (win_id)
    );

    vic_out_shaper #(
        .PULSE_W (LEN_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ctl_q.en),
        .pol_i     (ctl_q.pol),
        .emu_i     (ctl_q.emu),
        .plen_i    (ctl_q.plen),
        .any_req_i (|(pending & mask)),
        .capture_i (capture),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/vic_checker.sv
// Module: protocol and state checks for the interrupt controller,
// attached to the top through bind. Observes only; drives nothing.
module vic_checker #(
    parameter int  NUM_SRC = 32,
    parameter int  ADDR_W  = 8,
    parameter int  DATA_W  = 32,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic               irq_o,
    input logic               ctl_en,
    input logic               ctl_pol,
    input logic               ctl_emu,
    input logic               serving,
    input logic [IDX_W-1:0]   cur_id,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] mask,
    input logic [DATA_W-1:0]  vec_q
);

    logic [NUM_SRC-1:0] below_cur;
    logic [NUM_SRC-1:0] wbits;
    logic               wr_set, wr_clr, wr_soft, wr_eoi;

    assign below_cur = (NUM_SRC'(1) << cur_id) - NUM_SRC'(1);
    assign wbits     = bus_wdata_i[NUM_SRC-1:0];
    assign wr_set    = bus_wr_i && (bus_addr_i == ADDR_W'(8'h08));
    assign wr_clr    = bus_wr_i && (bus_addr_i == ADDR_W'(8'h0C));
    assign wr_soft   = bus_wr_i && (bus_addr_i == ADDR_W'(8'h18));
    assign wr_eoi    = bus_wr_i && (bus_addr_i == ADDR_W'(8'h1C));

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(wbits)) == $past(wbits)));                 // R4
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(wbits)) == '0));                           // R4
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serving) |-> (((($past(pending & mask)) >> cur_id) & NUM_SRC'(1)) != '0)
                           && (($past(pending & mask) & below_cur) == '0));   // R5
    AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && !wr_eoi) |=> $stable(vec_q));                            // R6
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !serving |-> (vec_q == '0));                                         // R7
    AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_soft |=> ((pending & $past(wbits)) == $past(wbits)));             // R8
    AST_LEVEL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !ctl_emu && (|(pending & mask))) |-> (irq_o != ctl_pol)); // R9
    AST_NO_TAKE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !serving) |=> !serving);                                 // R10
    AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (irq_o == ctl_pol));                                     // R10

endmodule

bind vec_irq_ctrl vic_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .ctl_en      (ctl_q.en),
    .ctl_pol     (ctl_q.pol),
    .ctl_emu     (ctl_q.emu),
    .serving     (serving),
    .cur_id      (cur_id),
    .pending     (pending),
    .mask        (mask),
    .vec_q       (vec_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks with hand-computed values.
module vec_irq_ctrl_tb_top;

    localparam int          N        = 32;
    localparam logic [31:0] EDGE_CFG = 32'h0000_00FF;  // lines 0..7 edge
    localparam logic [31:0] RISE_CFG = 32'hFFFF_FF0F;  // lines 4..7 falling

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = 32'h0000_00F0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl #(
        .NUM_SRC  (N),
        .ADDR_W   (8),
        .DATA_W   (32),
        .SRC_EDGE (EDGE_CFG),
        .SRC_RISE (RISE_CFG)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_pend, m_mask, m_var, m_prev;
    logic [18:0] m_ctl;
    logic [31:0] m_tbl [N];
    bit          m_busy;
    int          m_cur, m_cnt;

    always @(posedge clk) begin : model
        logic [31:0] hit, clr, req;
        int          win;
        bit          cap;
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_var = '0; m_ctl = '0;
            m_prev = ~RISE_CFG; m_busy = 0; m_cur = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) m_tbl[i] = '0;
        end else begin
            hit = '0;
            for (int i = 0; i < N; i++) begin
                if (EDGE_CFG[i])
                    hit[i] = RISE_CFG[i] ? (src[i] && !m_prev[i]) : (!src[i] && m_prev[i]);
                else
                    hit[i] = (src[i] == RISE_CFG[i]);
            end
            if (wr && addr == 8'h18) hit = hit | wdata;
            req = m_pend & m_mask;
            win = -1;
            for (int i = N - 1; i >= 0; i--) if (req[i]) win = i;
            cap = !m_busy && m_ctl[0] && (win >= 0);
            clr = '0;
            if (wr && addr == 8'h1C && m_busy) begin
                clr[m_cur] = 1'b1; m_busy = 0; m_var = '0;
            end
            if (cap) begin
                m_busy = 1; m_cur = win; m_var = m_tbl[win];
            end
            if (cap && m_ctl[2]) m_cnt = (m_ctl[18:3] == 0) ? 1 : int'(m_ctl[18:3]);
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_pend = (m_pend & ~clr) | hit;
            if (wr) begin
                if (addr[7]) m_tbl[addr[6:2]] = wdata;
                else if (addr == 8'h00) m_ctl = wdata[18:0];
                else if (addr == 8'h08) m_mask = m_mask | wdata;
                else if (addr == 8'h0C) m_mask = m_mask & ~wdata;
            end
            m_prev = src;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a[7]) return m_tbl[a[6:2]];
        case (a)
            8'h00:   return {13'b0, m_ctl};
            8'h04:   return m_pend;
            8'h10:   return m_mask;
            8'h14:   return m_var;
            default: return '0;
        endcase
    endfunction

    function automatic logic m_out();
        logic act;
        act = m_ctl[0] && (m_ctl[2] ? (m_cnt > 0) : ((m_pend & m_mask) != 0));
        return act ^ m_ctl[1];
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a[7]) return "R5";
        case (a)
            8'h00:   return "R10";
            8'h04:   return "R3";
            8'h10:   return "R4";
            8'h14:   return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Compare output and read data with the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 host line", {31'b0, irq}, {31'b0, m_out()});
            chk(tag_of(addr), rdata, m_read(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        addr = a;
        #2;
        v = rdata;
    endtask

    task automatic set_line(int i, logic v);
        @(posedge clk); #1;
        src[i] = v;
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq) c++;
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        int          c;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h00, v); chk("R1 ctl", v, 32'h0);
        bus_read(8'h04, v); chk("R1 pending", v, 32'h0);
        bus_read(8'h10, v); chk("R1 mask", v, 32'h0);
        bus_read(8'h14, v); chk("R1 vector", v, 32'h0);
        bus_read(8'h84, v); chk("R1 table", v, 32'h0);
        chk("R1 host line", {31'b0, irq}, 32'h0);

        // R5 fill the vector table and read one entry back
        for (int i = 0; i < N; i++) bus_write(8'h80 + 8'(i * 4), 32'h8000_0000 | (i << 4));
        bus_read(8'h94, v); chk("R5 table entry 5", v, 32'h8000_0050);

        // R3 level line pending while disabled; R10 no output, no capture
        set_line(10, 1'b1); tick(2);
        bus_read(8'h04, v); chk("R3 level pending", v, 32'h0000_0400);
        bus_read(8'h14, v); chk("R10 no capture when disabled", v, 32'h0);
        chk("R10 line idle when disabled", {31'b0, irq}, 32'h0);

        // R4 mask set and clear
        bus_write(8'h08, 32'h0000_0408);
        bus_read(8'h10, v); chk("R4 set", v, 32'h0000_0408);
        bus_write(8'h0C, 32'h0000_0008);
        bus_read(8'h10, v); chk("R4 clear", v, 32'h0000_0400);
        bus_write(8'h08, 32'h0);
        bus_read(8'h10, v); chk("R4 zero bits", v, 32'h0000_0400);
        bus_write(8'h08, 32'h0010_0028);
        bus_read(8'h10, v); chk("R4 set more", v, 32'h0010_0428);
        bus_read(8'h08, v); chk("R11 write-only reads 0", v, 32'h0);

        // R5 enable and take line 10; R9 level output
        bus_write(8'h00, 32'h1); tick(2);
        bus_read(8'h14, v); chk("R5 vector of line 10", v, 32'h8000_00A0);
        chk("R9 level active", {31'b0, irq}, 32'h1);

        // R6 a lower line arrives while 10 is in service
        set_line(3, 1'b1); set_line(3, 1'b0); tick(2);
        bus_read(8'h04, v); chk("R2 rising edge pending", v, 32'h0000_0408);
        bus_read(8'h14, v); chk("R6 vector frozen", v, 32'h8000_00A0);

        // R7 acknowledge: 10 stays pending (R3), line 3 wins next
        bus_write(8'h1C, 32'h0); tick(3);
        bus_read(8'h04, v); chk("R3 held level stays pending", v, 32'h0000_0408);
        bus_read(8'h14, v); chk("R5 lowest wins", v, 32'h8000_0030);
        bus_write(8'h1C, 32'h0); tick(3);
        bus_read(8'h04, v); chk("R7 acknowledge clears", v, 32'h0000_0400);
        bus_read(8'h14, v); chk("R5 line 10 again", v, 32'h8000_00A0);
        set_line(10, 1'b0);
        bus_write(8'h1C, 32'h0); tick(2);
        bus_read(8'h04, v); chk("R7 final clear", v, 32'h0);
        bus_read(8'h14, v); chk("R7 vector zero after ack", v, 32'h0);
        chk("R9 level inactive", {31'b0, irq}, 32'h0);

        // R2 falling edge line 5
        set_line(5, 1'b0); tick(3);
        bus_read(8'h14, v); chk("R2 falling edge taken", v, 32'h8000_0050);
        bus_write(8'h1C, 32'h0); tick(2);
        bus_read(8'h04, v); chk("R2 held low not re-pending", v, 32'h0);
        set_line(5, 1'b1); tick(2);
        bus_read(8'h04, v); chk("R2 rise ignored on falling line", v, 32'h0);

        // R8 software request while disabled; R7 ack with nothing in service
        bus_write(8'h00, 32'h0);
        bus_write(8'h18, 32'h0010_0000); tick(2);
        bus_read(8'h04, v); chk("R8 software request", v, 32'h0010_0000);
        bus_write(8'h1C, 32'h0); tick(2);
        bus_read(8'h04, v); chk("R7 idle ack ignored", v, 32'h0010_0000);

        // R10 polarity: active low
        bus_write(8'h00, 32'h3); tick(3);
        bus_read(8'h14, v); chk("R5 vector of line 20", v, 32'h8000_0140);
        chk("R10 active low asserted", {31'b0, irq}, 32'h0);
        bus_write(8'h1C, 32'h0); tick(2);
        chk("R10 active low idle", {31'b0, irq}, 32'h1);

        // R9 pulse mode, length 5
        bus_write(8'h00, 32'h0000_002D);
        bus_write(8'h18, 32'h0000_0008);
        count_high(20, c);
        chk("R9 pulse length 5", 32'(c), 32'd5);
        bus_write(8'h1C, 32'h0);

        // R9 pulse mode, length 0 treated as 1
        bus_write(8'h00, 32'h0000_0005);
        bus_write(8'h18, 32'h0000_0008);
        count_high(20, c);
        chk("R9 pulse length 0", 32'(c), 32'd1);
        bus_write(8'h1C, 32'h0);

        // R4 masked-off pending line is not taken
        bus_write(8'h00, 32'h1);
        bus_write(8'h18, 32'h8000_0000); tick(3);
        bus_read(8'h04, v); chk("R4 masked line pending", v, 32'h8000_0000);
        bus_read(8'h14, v); chk("R4 masked line not taken", v, 32'h0);
        chk("R4 masked line no output", {31'b0, irq}, 32'h0);
        bus_write(8'h08, 32'h8000_0000); tick(3);
        bus_read(8'h14, v); chk("R5 vector of line 31", v, 32'h8000_01F0);
        bus_write(8'h1C, 32'h0); tick(3);
        bus_read(8'h04, v); chk("R7 last clear", v, 32'h0);

        report();
    end

endmodule